// File: doc/BRIEF.md
# AHB Slave Response Protocol Monitor

This block is a synthesizable checker that observes the control signals between an AHB-style bus master and a single slave. Every clock it classifies the observed behaviour as legal, illegal on the slave's part, or outside the master's allowed stimulus. It does this with a complete state machine that has four tracking states and two absorbing verdict states. Entering one verdict state means the slave answered wrongly. Entering the other means the master issued a sequence it must never issue, so anything the slave does afterwards is irrelevant.

The monitor sits beside a slave in simulation, emulation or silicon. It reads the select, the incoming bus-ready, the transfer type, and the slave's own ready and response outputs. It drives nothing on the bus. It reports two sticky flags and its current tracking state for debug. Address, data, burst length, split/retry and multi-slave arbitration are not examined.

Top module: `ahb_rsp_monitor`

## Requirements
- R1: While `rst_n` is low, `state_o` reads 0 (origin) and both `vio_o` and `dc_o` are low. State codes are origin=0, quiet=1, data=2, stall=3, violation=4, don't-care=5.
- R2: In origin, a cycle without both `sel_i` and `bus_ready_i` high leaves the state at origin on the next edge.
- R3: In origin, a started cycle (`sel_i` and `bus_ready_i` high) moves to data when `trans_i` is NONSEQ (2'b10), and to quiet when `trans_i` is IDLE (2'b00) or BUSY (2'b01).
- R4: In origin, a started cycle with `trans_i` = SEQ (2'b11) moves to don't-care, and `dc_o` rises after that same edge.
- R5: In quiet, a slave response with `slv_ready_i` low or `slv_resp_i` other than OKAY (2'b00) moves to violation, and `vio_o` rises after that same edge.
- R6: In quiet, data or stall, a response with `slv_ready_i` high and OKAY picks the next state from the new request: `sel_i` low gives origin, IDLE/BUSY gives quiet, NONSEQ/SEQ gives data.
- R7: In data or stall, `slv_ready_i` low with OKAY moves to (or stays in) stall.
- R8: In data or stall, any non-OKAY `slv_resp_i` moves to violation, whatever the ready level.
- R9: Violation and don't-care are absorbing. No input pattern changes the state or the flags until reset.
- R10: `vio_o` is high exactly when the state is violation, and `dc_o` is high exactly when the state is don't-care. The two flags are never high together, and don't-care wins if both verdicts arise in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Slave select from the decoder |
| bus_ready_i | input | 1 | Ready seen on the bus by the slave |
| trans_i | input | 2 | Transfer type (IDLE 00, BUSY 01, NONSEQ 10, SEQ 11) |
| slv_ready_i | input | 1 | Ready driven by the slave |
| slv_resp_i | input | 2 | Response driven by the slave (OKAY 00) |
| vio_o | output | 1 | Sticky flag for an illegal slave response |
| dc_o | output | 1 | Sticky flag for an illegal master sequence |
| state_o | output | 3 | Current monitor state code |

## Verification
Each of the six states is reached from reset by a short directed path. In each state the bench then applies all 128 combinations of select, bus-ready, transfer type, slave ready and slave response. The next state and both flags are compared with a model written from the requirements. In origin, the sweep separates idling from the three kinds of started transfer, including the forbidden SEQ start. In quiet, data and stall, it separates a proper completion, a wait-state insertion and every bad response, and it checks that completions branch on the new request. In the two verdict states, the same sweep shows that no stimulus at all can leave them.

// File: rtl/ahb_mon_pkg.sv
package ahb_mon_pkg;

  localparam int TRANS_W = 2;
  localparam int RESP_W  = 2;
  localparam int ST_W    = 3;

  typedef enum logic [TRANS_W-1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [RESP_W-1:0] RESP_OKAY = '0;

  typedef enum logic [ST_W-1:0] {
    MS_ORIGIN = 3'd0,
    MS_QUIET  = 3'd1,
    MS_DATA   = 3'd2,
    MS_STALL  = 3'd3,
    MS_VIO    = 3'd4,
    MS_DC     = 3'd5
  } mon_st_e;

  // destination class picked by a freshly presented request
  typedef enum logic [1:0] {
    NX_ORIGIN = 2'd0,
    NX_QUIET  = 2'd1,
    NX_DATA   = 2'd2
  } nx_kind_e;

  function automatic mon_st_e kind_to_state(input nx_kind_e k);
    case (k)
      NX_QUIET: kind_to_state = MS_QUIET;
      NX_DATA:  kind_to_state = MS_DATA;
      default:  kind_to_state = MS_ORIGIN;
    endcase
  endfunction

endpackage

// File: rtl/ahb_mon_decode.sv
module ahb_mon_decode
  import ahb_mon_pkg::*;
(
  input  logic               sel,
  input  logic               bus_ready,
  input  logic [TRANS_W-1:0] trans,
  input  logic               slv_ready,
  input  logic [RESP_W-1:0]  slv_resp,
  output logic               start,
  output logic               first_seq,
  output logic               done_ok,
  output logic               stall_ok,
  output logic               resp_bad,
  output nx_kind_e           nx_kind
);

  logic idle_like;

  always_comb begin
    idle_like = (trans == TR_IDLE) || (trans == TR_BUSY);
    start     = sel && bus_ready;
    first_seq = start && (trans == TR_SEQ);
    resp_bad  = (slv_resp != RESP_OKAY);
    done_ok   = slv_ready && !resp_bad;
    stall_ok  = !slv_ready && !resp_bad;
    if (!sel)           nx_kind = NX_ORIGIN;
    else if (idle_like) nx_kind = NX_QUIET;
    else                nx_kind = NX_DATA;
  end

endmodule

// File: rtl/ahb_mon_fsm.sv
module ahb_mon_fsm
  import ahb_mon_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     first_seq,
  input  logic     done_ok,
  input  logic     stall_ok,
  input  logic     resp_bad,
  input  nx_kind_e nx_kind,
  output mon_st_e  st_q,
  output mon_st_e  st_d
);

  logic    dc_hit;
  logic    vio_hit;
  logic    adv;
  mon_st_e go;

  // next-state process
  always_comb begin
    dc_hit  = 1'b0;
    vio_hit = 1'b0;
    go      = st_q;
    case (st_q)
      MS_ORIGIN: begin
        if (start) begin
          if (first_seq) dc_hit = 1'b1;
          else           go     = kind_to_state(nx_kind);
        end
      end
      MS_QUIET: begin
        if (!done_ok) vio_hit = 1'b1;
        else          go      = kind_to_state(nx_kind);
      end
      MS_DATA, MS_STALL: begin
        if (resp_bad)      vio_hit = 1'b1;
        else if (stall_ok) go      = MS_STALL;
        else               go      = kind_to_state(nx_kind);
      end
      MS_VIO, MS_DC: go = st_q;
      default:       vio_hit = 1'b1;
    endcase
    // an illegal stimulus makes the slave's answer irrelevant
    if (dc_hit)       st_d = MS_DC;
    else if (vio_hit) st_d = MS_VIO;
    else              st_d = go;
    adv = (st_d != st_q);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= MS_ORIGIN;
    else if (adv) st_q <= st_d;
  end

  a_r2_origin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_ORIGIN && !start) |=> (st_q == MS_ORIGIN));

  a_r4_seq_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_ORIGIN && first_seq) |=> (st_q == MS_DC));

  a_r5_quiet_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_QUIET && !done_ok) |=> (st_q == MS_VIO));

  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == MS_DATA || st_q == MS_STALL) && stall_ok) |=> (st_q == MS_STALL));

  a_r8_bad_resp: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == MS_DATA || st_q == MS_STALL) && resp_bad) |=> (st_q == MS_VIO));

  a_r9_absorb: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_VIO || st_q == MS_DC) |=> $stable(st_q));

endmodule

// File: rtl/ahb_mon_verdict.sv
module ahb_mon_verdict
  import ahb_mon_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  mon_st_e st_d,
  input  mon_st_e st_q,
  output logic    vio_q,
  output logic    dc_q
);

  logic set_vio;
  logic set_dc;

  always_comb begin
    set_dc  = (st_d == MS_DC)  && !vio_q && !dc_q;
    set_vio = (st_d == MS_VIO) && !vio_q && !dc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vio_q <= 1'b0;
      dc_q  <= 1'b0;
    end else begin
      if (set_vio) vio_q <= 1'b1;
      if (set_dc)  dc_q  <= 1'b1;
    end
  end

  a_r9_vio_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    vio_q |=> vio_q);

  a_r9_dc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dc_q |=> dc_q);

  a_r10_vio_state: assert property (@(posedge clk) disable iff (!rst_n)
    vio_q == (st_q == MS_VIO));

  a_r10_dc_state: assert property (@(posedge clk) disable iff (!rst_n)
    dc_q == (st_q == MS_DC));

endmodule

// File: rtl/ahb_rsp_monitor.sv
module ahb_rsp_monitor
  import ahb_mon_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_i,
  input  logic               bus_ready_i,
  input  logic [TRANS_W-1:0] trans_i,
  input  logic               slv_ready_i,
  input  logic [RESP_W-1:0]  slv_resp_i,
  output logic               vio_o,
  output logic               dc_o,
  output logic [ST_W-1:0]    state_o
);

  logic     start;
  logic     first_seq;
  logic     done_ok;
  logic     stall_ok;
  logic     resp_bad;
  nx_kind_e nx_kind;
  mon_st_e  st_q;
  mon_st_e  st_d;

  ahb_mon_decode u_decode (
    .sel       (sel_i),
    .bus_ready (bus_ready_i),
    .trans     (trans_i),
    .slv_ready (slv_ready_i),
    .slv_resp  (slv_resp_i),
    .start     (start),
    .first_seq (first_seq),
    .done_ok   (done_ok),
    .stall_ok  (stall_ok),
    .resp_bad  (resp_bad),
    .nx_kind   (nx_kind)
  );

  ahb_mon_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .first_seq (first_seq),
    .done_ok   (done_ok),
    .stall_ok  (stall_ok),
    .resp_bad  (resp_bad),
    .nx_kind   (nx_kind),
    .st_q      (st_q),
    .st_d      (st_d)
  );

  ahb_mon_verdict u_verdict (
    .clk   (clk),
    .rst_n (rst_n),
    .st_d  (st_d),
    .st_q  (st_q),
    .vio_q (vio_o),
    .dc_q  (dc_o)
  );

  assign state_o = st_q;

  a_r10_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({vio_o, dc_o}) <= 1);

endmodule

// File: tb/test_ahb_rsp_monitor.sv
module test_ahb_rsp_monitor;

  logic       clk;
  logic       rst_n;
  logic       sel;
  logic       brdy;
  logic [1:0] tr;
  logic       srdy;
  logic [1:0] rsp;
  logic       vio;
  logic       dc;
  logic [2:0] st;

  int checks;
  int failures;

  ahb_rsp_monitor i_ahb_rsp_monitor (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_i       (sel),
    .bus_ready_i (brdy),
    .trans_i     (tr),
    .slv_ready_i (srdy),
    .slv_resp_i  (rsp),
    .vio_o       (vio),
    .dc_o        (dc),
    .state_o     (st)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // next state per the requirements
  function automatic int model(input int s, input logic a, input logic b,
                               input logic [1:0] t, input logic r, input logic [1:0] p);
    int pick;
    pick = !a ? 0 : (t[1] == 1'b0 ? 1 : 2);
    case (s)
      0: model = !(a && b) ? 0 : (t == 2'b11 ? 5 : (t[1] ? 2 : 1));
      1: model = (!r || p != 2'b00) ? 4 : pick;
      2, 3: model = (p != 2'b00) ? 4 : (!r ? 3 : pick);
      default: model = s;
    endcase
  endfunction

  function automatic string tag(input int s, input logic a, input logic b,
                                input logic [1:0] t, input logic r, input logic [1:0] p);
    case (s)
      0: tag = !(a && b) ? "R2" : (t == 2'b11 ? "R4" : "R3");
      1: tag = (!r || p != 2'b00) ? "R5" : "R6";
      2, 3: tag = (p != 2'b00) ? "R8" : (!r ? "R7" : "R6");
      default: tag = "R9";
    endcase
  endfunction

  task automatic check_out(input string req, input int exp);
    checks++;
    if (st != exp[2:0]) begin
      failures++;
      $display("FAIL %s state actual=%0d expected=%0d", req, st, exp);
    end
    checks++;
    if (vio != (exp == 4) || dc != (exp == 5)) begin
      failures++;
      $display("FAIL R10 flags vio/dc actual=%0b%0b expected=%0b%0b",
               vio, dc, (exp == 4), (exp == 5));
    end
  endtask

  task automatic step(input logic a, input logic b, input logic [1:0] t,
                      input logic r, input logic [1:0] p);
    sel = a; brdy = b; tr = t; srdy = r; rsp = p;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(1'b0, 1'b0, 2'b00, 1'b1, 2'b00);
    check_out("R1", 0);
    rst_n = 1'b1;
  endtask

  task automatic reach(input int s);
    case (s)
      1: step(1'b1, 1'b1, 2'b00, 1'b1, 2'b00);
      2: step(1'b1, 1'b1, 2'b10, 1'b1, 2'b00);
      3: begin
        step(1'b1, 1'b1, 2'b10, 1'b1, 2'b00);
        step(1'b0, 1'b0, 2'b00, 1'b0, 2'b00);
      end
      4: begin
        step(1'b1, 1'b1, 2'b01, 1'b1, 2'b00);
        step(1'b0, 1'b0, 2'b00, 1'b0, 2'b00);
      end
      5: step(1'b1, 1'b1, 2'b11, 1'b1, 2'b00);
      default: ;
    endcase
    check_out(s == 3 ? "R7" : (s == 4 ? "R5" : (s == 5 ? "R4" : "R3")), s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    sel = 1'b0; brdy = 1'b0; tr = 2'b00; srdy = 1'b1; rsp = 2'b00;
    @(negedge clk);
    for (int s = 0; s < 6; s++) begin
      for (int c = 0; c < 128; c++) begin
        logic a, b, r;
        logic [1:0] t, p;
        a = c[6]; b = c[5]; t = c[4:3]; r = c[2]; p = c[1:0];
        do_reset();
        reach(s);
        step(a, b, t, r, p);
        check_out(tag(s, a, b, t, r, p), model(s, a, b, t, r, p));
        if (s >= 4) begin
          // R9: a second arbitrary cycle still cannot leave the verdict
          step(~a, ~b, ~t, ~r, ~p);
          check_out("R9", s);
        end
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule